// File: doc/BRIEF.md
# DMA Interrupt Control Register

This block is the shared interrupt control register of a multi-channel DMA controller. It has two jobs. It collects completion events from seven channels and merges them into one interrupt request toward the system interrupt controller. It also decides whether a write to a channel's control register actually launches that channel. Data movement is handled elsewhere.

The register holds the following fields:
- a six-bit scratch field;
- a bus-error bit, which on its own forces a request;
- seven per-channel interrupt enables;
- a master enable;
- seven per-channel completion flags, cleared by writing a one to them;
- a read-only "sent" bit.

The sent bit mirrors the request condition. The outgoing request is a single-cycle pulse, produced only when the condition moves from false to true. A second register, the channel enable word, holds one start-enable bit per channel. A control write launches its channel only when that bit is set.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the interrupt register and the enable word read 0, and `irq_pulse` and `start_pulse` are low.
- R2: On an interrupt register write, bits 0-5, bit 15 (bus error), bits 16-22 (per-channel enables, channel n at 16+n) and bit 23 (master enable) take the written value. Bits 6-14 always read 0, and the written bit 31 has no effect.
- R3: Flag bits 24-30 (channel n at 24+n) clear where the written word has a 1 and are unchanged where it has a 0.
- R4: A completion pulse on channel n sets flag 24+n only if enable bit 16+n was set before that cycle. A pulse and a clearing write to the same flag in one cycle leave the flag set.
- R5: Bit 31 reads 1 exactly when the request condition holds: (master enable and any flag set) or bus error set.
- R6: `irq_pulse` is high for one cycle, in the cycle in which bit 31 first reads 1 after reading 0. It is not raised again while the condition stays true.
- R7: Once the condition has gone false, its next return to true raises `irq_pulse` again.
- R8: The request condition is updated both by completion pulses and by register writes.
- R9: The channel enable word is fully writable and reads back the written value.
- R10: A control write to channel n with bit 24 set gives a one-cycle `start_pulse[n]` in the cycle after the write. This happens only when bit 3+4n of the enable word is set; otherwise no start is given.
- R11: Channel 5 and channel code 7 never produce a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| icr_wr_en | input | 1 | Write strobe for the interrupt register |
| icr_wr_data | input | 32 | Write data for the interrupt register |
| done_pulse | input | 7 | Per-channel completion pulses |
| icr_rd_data | output | 32 | Current interrupt register value |
| irq_pulse | output | 1 | Single-cycle request to the system interrupt controller |
| pen_wr_en | input | 1 | Write strobe for the channel enable word |
| pen_wr_data | input | 32 | Write data for the channel enable word |
| pen_rd_data | output | 32 | Current channel enable word |
| ctl_wr_en | input | 1 | Channel control write strobe |
| ctl_wr_ch | input | 3 | Channel addressed by the control write |
| ctl_wr_data | input | 32 | Control write data; bit 24 requests a start |
| start_pulse | output | 7 | Per-channel start pulses |

## Verification
The request logic is tested with the following patterns:
- Completion pulses on an enabled channel and on a disabled channel, which separate flag gating from flag setting.
- Clearing writes that remove one of two flags and then the last flag, which separate "condition still true" from "condition dropped".
- Toggling the master enable while a flag is pending, and raising the bus error with no flag set. These show that the pulse follows condition edges rather than individual events.
- A pulse and a clear landing on the same flag in the same cycle, which exposes the priority between set and clear.

Start gating is tested against an all-enabled word and a word with one bit missing. Every channel code is tried, including the one with no control register.

// File: rtl/dicr_pkg.sv
package dicr_pkg;

    localparam int NCH        = 7;
    localparam int DW         = 32;
    localparam int CHW        = $clog2(NCH + 1);
    localparam int AUX_W      = 6;
    localparam int AUX_LSB    = 0;
    localparam int BERR_BIT   = 15;
    localparam int EN_LSB     = 16;
    localparam int MASTER_BIT = EN_LSB + NCH;
    localparam int FLAG_LSB   = 24;
    localparam int SENT_BIT   = 31;
    localparam int PEN_OFS    = 3;
    localparam int PEN_STRIDE = 4;
    localparam int GO_BIT     = 24;

    typedef struct packed {
        logic [NCH-1:0]   flag;
        logic             master;
        logic [NCH-1:0]   en;
        logic             berr;
        logic [AUX_W-1:0] aux;
    } icr_fields_t;

    function automatic logic req_cond(input icr_fields_t f);
        return (f.master && (|f.flag)) || f.berr;
    endfunction

    function automatic logic [DW-1:0] icr_pack(input icr_fields_t f, input logic sent);
        logic [DW-1:0] w;
        w = '0;
        w[AUX_LSB +: AUX_W] = f.aux;
        w[BERR_BIT]         = f.berr;
        w[EN_LSB +: NCH]    = f.en;
        w[MASTER_BIT]       = f.master;
        w[FLAG_LSB +: NCH]  = f.flag;
        w[SENT_BIT]         = sent;
        return w;
    endfunction

endpackage

// File: rtl/dicr_icr_reg.sv
module dicr_icr_reg
    import dicr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    input  logic [NCH-1:0]    done,
    output icr_fields_t       fields_q,
    output logic              cond_nxt
);

    icr_fields_t fields_d;
    logic [NCH-1:0] flag_d;

    // Flags: write-one-to-clear, then gated completion sets (set dominates)
    for (genvar g = 0; g < NCH; g++) begin : g_flag
        logic kept;
        assign kept      = wr_en ? (fields_q.flag[g] & ~wr_data[FLAG_LSB+g]) : fields_q.flag[g];
        assign flag_d[g] = kept | (done[g] & fields_q.en[g]);
    end

    always_comb begin
        fields_d      = fields_q;
        fields_d.flag = flag_d;
        if (wr_en) begin
            fields_d.aux    = wr_data[AUX_LSB +: AUX_W];
            fields_d.berr   = wr_data[BERR_BIT];
            fields_d.en     = wr_data[EN_LSB +: NCH];
            fields_d.master = wr_data[MASTER_BIT];
        end
    end

    assign cond_nxt = req_cond(fields_d);

    always_ff @(posedge clk) begin
        if (rst) fields_q <= '0;
        else     fields_q <= fields_d;
    end

endmodule

// File: rtl/dicr_req_edge.sv
module dicr_req_edge (
    input  logic clk,
    input  logic rst,
    input  logic cond_nxt,
    output logic sent_q,
    output logic irq_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sent_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q  <= cond_nxt & ~sent_q;
            sent_q <= cond_nxt;
        end
    end

endmodule

// File: rtl/dicr_start_gate.sv
module dicr_start_gate
    import dicr_pkg::*;
#(
    parameter logic [NCH-1:0] START_CAPABLE = 7'b1011111
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pen_wr_en,
    input  logic [DW-1:0]   pen_wr_data,
    output logic [DW-1:0]   pen_q,
    input  logic            ctl_wr_en,
    input  logic [CHW-1:0]  ctl_wr_ch,
    input  logic [DW-1:0]   ctl_wr_data,
    output logic [NCH-1:0]  start_q
);

    logic [NCH-1:0] start_d;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        if (START_CAPABLE[g]) begin : g_cap
            assign start_d[g] = ctl_wr_en && (ctl_wr_ch == CHW'(g))
                              && ctl_wr_data[GO_BIT]
                              && pen_q[PEN_OFS + PEN_STRIDE*g];
        end else begin : g_none
            assign start_d[g] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pen_q   <= '0;
            start_q <= '0;
        end else begin
            start_q <= start_d;
            if (pen_wr_en) pen_q <= pen_wr_data;
        end
    end

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dicr_pkg::*;
#(
    parameter logic [NCH-1:0] START_CAPABLE = 7'b1011111
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            icr_wr_en,
    input  logic [DW-1:0]   icr_wr_data,
    input  logic [NCH-1:0]  done_pulse,
    output logic [DW-1:0]   icr_rd_data,
    output logic            irq_pulse,
    input  logic            pen_wr_en,
    input  logic [DW-1:0]   pen_wr_data,
    output logic [DW-1:0]   pen_rd_data,
    input  logic            ctl_wr_en,
    input  logic [CHW-1:0]  ctl_wr_ch,
    input  logic [DW-1:0]   ctl_wr_data,
    output logic [NCH-1:0]  start_pulse
);

    icr_fields_t fields;
    logic        cond_nxt;
    logic        sent;

    dicr_icr_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (icr_wr_en),
        .wr_data  (icr_wr_data),
        .done     (done_pulse),
        .fields_q (fields),
        .cond_nxt (cond_nxt)
    );

    dicr_req_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .cond_nxt (cond_nxt),
        .sent_q   (sent),
        .irq_q    (irq_pulse)
    );

    dicr_start_gate #(.START_CAPABLE(START_CAPABLE)) u_gate (
        .clk         (clk),
        .rst         (rst),
        .pen_wr_en   (pen_wr_en),
        .pen_wr_data (pen_wr_data),
        .pen_q       (pen_rd_data),
        .ctl_wr_en   (ctl_wr_en),
        .ctl_wr_ch   (ctl_wr_ch),
        .ctl_wr_data (ctl_wr_data),
        .start_q     (start_pulse)
    );

    assign icr_rd_data = icr_pack(fields, sent);

endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk
    import dicr_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            icr_wr_en,
    input logic [DW-1:0]   icr_wr_data,
    input logic [NCH-1:0]  done_pulse,
    input logic [DW-1:0]   icr_rd_data,
    input logic            irq_pulse,
    input logic            ctl_wr_en,
    input logic [NCH-1:0]  start_pulse
);

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse); // R6

    AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> (icr_rd_data[SENT_BIT] && !$past(icr_rd_data[SENT_BIT]))); // R6

    AST_RISE_GIVES_IRQ: assert property (@(posedge clk) disable iff (rst)
        $rose(icr_rd_data[SENT_BIT]) |-> irq_pulse); // R7

    AST_SENT_TRACKS_COND: assert property (@(posedge clk) disable iff (rst)
        icr_rd_data[SENT_BIT] == ((icr_rd_data[MASTER_BIT] && (|icr_rd_data[FLAG_LSB +: NCH]))
                                  || icr_rd_data[BERR_BIT])); // R5

    AST_FLAG_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (icr_rd_data[FLAG_LSB +: NCH] & ~$past(icr_rd_data[FLAG_LSB +: NCH])
         & ~($past(icr_rd_data[EN_LSB +: NCH]) & $past(done_pulse))) == '0); // R4

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(icr_wr_en) |-> ((icr_rd_data[FLAG_LSB +: NCH] & $past(icr_wr_data[FLAG_LSB +: NCH])
                               & ~$past(done_pulse)) == '0)); // R3

    AST_START_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (|start_pulse) |-> ($past(ctl_wr_en) && $onehot0(start_pulse))); // R10

    AST_NO_CH5_START: assert property (@(posedge clk) disable iff (rst)
        !start_pulse[5]); // R11

endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .icr_wr_en   (icr_wr_en),
    .icr_wr_data (icr_wr_data),
    .done_pulse  (done_pulse),
    .icr_rd_data (icr_rd_data),
    .irq_pulse   (irq_pulse),
    .ctl_wr_en   (ctl_wr_en),
    .start_pulse (start_pulse)
);

// File: tb/dma_irq_ctrl_tb_top.sv
module dma_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        icr_wr_en = 1'b0;
    logic [31:0] icr_wr_data = '0;
    logic [6:0]  done_pulse = '0;
    logic [31:0] icr_rd_data;
    logic        irq_pulse;
    logic        pen_wr_en = 1'b0;
    logic [31:0] pen_wr_data = '0;
    logic [31:0] pen_rd_data;
    logic        ctl_wr_en = 1'b0;
    logic [2:0]  ctl_wr_ch = '0;
    logic [31:0] ctl_wr_data = '0;
    logic [6:0]  start_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dma_irq_ctrl dut_i (
        .clk(clk), .rst(rst),
        .icr_wr_en(icr_wr_en), .icr_wr_data(icr_wr_data),
        .done_pulse(done_pulse), .icr_rd_data(icr_rd_data), .irq_pulse(irq_pulse),
        .pen_wr_en(pen_wr_en), .pen_wr_data(pen_wr_data), .pen_rd_data(pen_rd_data),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_ch(ctl_wr_ch), .ctl_wr_data(ctl_wr_data),
        .start_pulse(start_pulse)
    );

    // {done[6:0], wr_en, wdata[31:0], exp_icr[31:0], exp_irq}
    localparam int NV = 20;
    localparam logic [72:0] VEC [NV] = '{
        {7'h00, 1'b1, 32'h00000000, 32'h00000000, 1'b0}, // R2 zero write
        {7'h00, 1'b1, 32'h00850000, 32'h00850000, 1'b0}, // R2 master + en0,en2
        {7'h02, 1'b0, 32'h00000000, 32'h00850000, 1'b0}, // R4 ch1 disabled
        {7'h01, 1'b0, 32'h00000000, 32'h81850000, 1'b1}, // R6 R8 first request
        {7'h04, 1'b0, 32'h00000000, 32'h85850000, 1'b0}, // R6 no repeat
        {7'h00, 1'b0, 32'h00000000, 32'h85850000, 1'b0}, // R6 idle
        {7'h00, 1'b1, 32'h01850000, 32'h84850000, 1'b0}, // R3 clear one flag
        {7'h00, 1'b1, 32'h04850000, 32'h00850000, 1'b0}, // R3 R5 last flag cleared
        {7'h04, 1'b0, 32'h00000000, 32'h84850000, 1'b1}, // R7 re-armed
        {7'h00, 1'b1, 32'h00050000, 32'h04050000, 1'b0}, // R5 R8 master off
        {7'h00, 1'b1, 32'h00858000, 32'h84858000, 1'b1}, // R5 R7 master + bus error
        {7'h00, 1'b1, 32'h0405803F, 32'h8005803F, 1'b0}, // R5 bus error alone, aux bits
        {7'h00, 1'b1, 32'h00000000, 32'h00000000, 1'b0}, // R5 all clear
        {7'h00, 1'b1, 32'hFF007FC0, 32'h00000000, 1'b0}, // R2 unmasked bits and bit 31 ignored
        {7'h00, 1'b1, 32'h00C00000, 32'h00C00000, 1'b0}, // R2 master + en6
        {7'h40, 1'b1, 32'h40C00000, 32'hC0C00000, 1'b1}, // R4 set beats clear
        {7'h40, 1'b0, 32'h00000000, 32'hC0C00000, 1'b0}, // R6 repeat event no pulse
        {7'h00, 1'b1, 32'h00400000, 32'h40400000, 1'b0}, // R3 zero keeps flag
        {7'h7F, 1'b0, 32'h00000000, 32'h40400000, 1'b0}, // R4 only enabled ch6
        {7'h00, 1'b1, 32'h40000000, 32'h00000000, 1'b0}  // R3 final clear
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic ctl_start(input logic [2:0] ch, input logic [31:0] d, input logic [6:0] exp,
                             input string req);
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_wr_ch = ch; ctl_wr_data = d;
        @(posedge clk); #1;
        chk(req, {25'd0, start_pulse}, {25'd0, exp});
        @(negedge clk);
        ctl_wr_en = 1'b0; ctl_wr_data = '0;
        @(posedge clk); #1;
        chk({req, " pulse ends"}, {25'd0, start_pulse}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 icr reset", icr_rd_data, 32'h0);
        chk("R1 pen reset", pen_rd_data, 32'h0);
        chk("R1 irq reset", {31'd0, irq_pulse}, 32'h0);
        chk("R1 start reset", {25'd0, start_pulse}, 32'h0);
        @(negedge clk); rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            done_pulse  = VEC[i][72:66];
            icr_wr_en   = VEC[i][65];
            icr_wr_data = VEC[i][64:33];
            @(posedge clk); #1;
            chk($sformatf("R2-vector %0d icr", i), icr_rd_data, VEC[i][32:1]);
            chk($sformatf("R6 vector %0d irq", i), {31'd0, irq_pulse}, {31'd0, VEC[i][0]});
        end
        @(negedge clk);
        done_pulse = '0; icr_wr_en = 1'b0; icr_wr_data = '0;

        // R9 enable word readback
        @(negedge clk);
        pen_wr_en = 1'b1; pen_wr_data = 32'h08888888;
        @(posedge clk); #1;
        chk("R9 pen readback", pen_rd_data, 32'h08888888);
        @(negedge clk); pen_wr_en = 1'b0;

        // R10 gated starts
        ctl_start(3'd2, 32'h01000000, 7'b0000100, "R10 ch2 start");
        ctl_start(3'd2, 32'h00FFFFFF, 7'b0000000, "R10 no go bit");
        ctl_start(3'd6, 32'h01000000, 7'b1000000, "R10 ch6 start");
        ctl_start(3'd5, 32'h01000000, 7'b0000000, "R11 ch5 never");
        ctl_start(3'd7, 32'hFFFFFFFF, 7'b0000000, "R11 code 7 never");

        @(negedge clk);
        pen_wr_en = 1'b1; pen_wr_data = 32'h08888880;
        @(posedge clk); #1;
        chk("R9 pen rewrite", pen_rd_data, 32'h08888880);
        @(negedge clk); pen_wr_en = 1'b0;
        ctl_start(3'd0, 32'h01000000, 7'b0000000, "R10 ch0 disabled");
        ctl_start(3'd1, 32'h01000000, 7'b0000010, "R10 ch1 start");

        // R1 reset from a busy state
        @(negedge clk);
        icr_wr_en = 1'b1; icr_wr_data = 32'h00808000;
        @(posedge clk); #1;
        chk("R5 bus error request", icr_rd_data, 32'h80808000);
        chk("R6 bus error pulse", {31'd0, irq_pulse}, 32'h1);
        @(negedge clk);
        icr_wr_en = 1'b0; rst = 1'b1;
        @(posedge clk); #1;
        chk("R1 icr after reset", icr_rd_data, 32'h0);
        chk("R1 pen after reset", pen_rd_data, 32'h0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 irq quiet after reset", {31'd0, irq_pulse}, 32'h0);

        finish_run();
    end

endmodule